// File: doc/BRIEF.md
# LED Channel Fault Status Register

This block keeps one health bit per output channel of a sixteen-channel constant-current sink driver. It watches each channel's drive request together with digital fault indications: a current-too-low flag, a voltage-too-high flag, a per-channel thermal trip and a die-level thermal trip. From these it builds a status word for the shift datapath to capture. A bit of 1 reports a healthy channel. A bit of 0 reports a fault, or a channel that was not driven and so could not be judged.

Open-load and short results are live: they are sampled on every clock and follow the flags. Thermal faults are sticky. A channel trip marks only that channel, and a die trip marks every channel. Such a mark stays after the part cools and is removed only by a clear pulse, which the mode logic sends when the device goes back to normal operation.

The block also gates the channel drive. A tripped channel, or every channel when the die trips, loses its enable on the next clock edge. The enable comes back on its own once the trip flag falls, provided the channel's drive request is still set.

Top module: `led_err_status`

## Requirements
- R1: While reset is held, and right after it, every status bit and every drive enable is 0 when no drive is requested.
- R2: A driven channel with no fault flags reports status 1 after the next rising clock edge.
- R3: A channel whose drive request was low at the last edge reports status 0, whatever its flags are.
- R4: A driven channel with its open-load flag high reports 0 after the next edge. Once the flag drops, it reports 1 again after the following edge.
- R5: A driven channel with its short flag high reports 0 after the next edge. This holds when the short-detect parameter is 1, which is the default.
- R6: A channel thermal trip drops that channel's drive enable on the next edge and leaves the other channels' enables unchanged.
- R7: When a trip flag falls, the drive enable returns on the next edge if the channel's drive request is still high.
- R8: A driven channel's thermal trip forces its status to 0. That 0 remains after the trip clears and stays until a clear pulse.
- R9: A die thermal trip drops every drive enable on the next edge and forces every status bit to 0. These 0s remain until a clear pulse.
- R10: A clear pulse removes all sticky thermal marks. After that edge, each bit shows its live open/short result again.
- R11: When a thermal trip and a clear pulse arrive in the same cycle, the trip wins and the status bit stays 0.
- R12: A drive enable is never 1 while its channel's drive request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_on | input | 16 | Per-channel drive request (output latch bits) |
| open_flag | input | 16 | Per-channel current-below-threshold indication |
| short_flag | input | 16 | Per-channel voltage-above-threshold indication |
| ch_hot | input | 16 | Per-channel thermal trip |
| die_hot | input | 1 | Die-level thermal trip |
| mode_clr | input | 1 | Clear pulse for sticky thermal marks |
| status | output | 16 | Status word, 1 = healthy |
| drive_en | output | 16 | Per-channel drive enable after thermal gating |

## Verification
The clear pulse and a new thermal trip can land in the same cycle. When that happens, the sticky mark is erased and set again on one edge. The bench forces this case directly, by raising the die trip and the clear pulse together, and it also lets random stimulus produce the overlap at low rates for both channel trips and die trips. The result is judged against a reference model where setting wins over clearing, so the affected bits must stay at 0 while untouched channels go back to their live values.

// File: rtl/led_err_status_pkg.sv
// Shared constants and helpers for the LED fault status register.
// Assumes the status encoding is active-high health (1 = good).
package led_err_status_pkg;
    localparam int unsigned NCH_DEFAULT = 16;
    localparam logic        HEALTHY     = 1'b1;

    // Live health of one channel from its flags; off channels cannot be judged.
    function automatic logic live_health(input logic on, input logic open_f,
                                         input logic short_f);
        return on & ~open_f & ~short_f;
    endfunction
endpackage

// File: rtl/led_err_glob_therm.sv
// Die-level thermal shutdown register.
// Registers the die trip flag so that all channels lose drive one edge later;
// assumes the flag is already synchronous to clk.
module led_err_glob_therm (
    input  logic clk,
    input  logic rst_n,
    input  logic die_hot_i,
    output logic glob_shut_o
);
    // Track the die trip with one register of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) glob_shut_o <= 1'b0;
        else        glob_shut_o <= die_hot_i;
    end
endmodule

// File: rtl/led_err_chan_slice.sv
// One channel of the fault status register.
// Holds the live open/short sample, the sticky thermal mark and the channel
// shutdown register. Assumes all inputs are synchronous to clk.
module led_err_chan_slice
    import led_err_status_pkg::*;
#(
    parameter bit SHORT_DETECT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_on_i,
    input  logic open_i,
    input  logic short_i,
    input  logic hot_i,
    input  logic glob_hot_i,
    input  logic glob_shut_i,
    input  logic clr_i,
    output logic status_o,
    output logic drive_en_o
);
    logic short_hit;
    logic live_q;
    logic therm_err_q;
    logic shut_q;
    logic therm_set;

    // Short detection exists only in the variant that asks for it.
    generate
        if (SHORT_DETECT) begin : g_short
            assign short_hit = short_i;
        end else begin : g_noshort
            assign short_hit = 1'b0;
        end
    endgenerate

    // A channel trip counts only while driven; a die trip marks every channel.
    assign therm_set = (hot_i & ch_on_i) | glob_hot_i;

    // Sample the live open/short health every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= live_health(ch_on_i, open_i, short_hit);
    end

    // Sticky thermal mark: a set wins over a clear that arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         therm_err_q <= 1'b0;
        else if (therm_set) therm_err_q <= 1'b1;
        else if (clr_i)     therm_err_q <= 1'b0;
    end

    // Channel shutdown follows the trip flag with one edge of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_q <= 1'b0;
        else        shut_q <= hot_i;
    end

    assign status_o   = live_q & ~therm_err_q;
    assign drive_en_o = ch_on_i & ~shut_q & ~glob_shut_i;
endmodule

// File: rtl/led_err_status.sv
// Fault status register for a multi-channel LED sink driver (top level).
// Instantiates one slice per channel and the die-level shutdown register.
// Assumes all flags come from synchronous comparator/sensor logic.
module led_err_status
    import led_err_status_pkg::*;
#(
    parameter int unsigned NCH          = NCH_DEFAULT,
    parameter bit          SHORT_DETECT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_on,
    input  logic [NCH-1:0] open_flag,
    input  logic [NCH-1:0] short_flag,
    input  logic [NCH-1:0] ch_hot,
    input  logic           die_hot,
    input  logic           mode_clr,
    output logic [NCH-1:0] status,
    output logic [NCH-1:0] drive_en
);
    logic glob_shut;

    led_err_glob_therm u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .die_hot_i  (die_hot),
        .glob_shut_o(glob_shut)
    );

    // One independent slice per channel.
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            led_err_chan_slice #(.SHORT_DETECT(SHORT_DETECT)) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .ch_on_i    (ch_on[i]),
                .open_i     (open_flag[i]),
                .short_i    (short_flag[i]),
                .hot_i      (ch_hot[i]),
                .glob_hot_i (die_hot),
                .glob_shut_i(glob_shut),
                .clr_i      (mode_clr),
                .status_o   (status[i]),
                .drive_en_o (drive_en[i])
            );
        end
    endgenerate
endmodule

// File: rtl/led_err_status_chk.sv
// Property checker for led_err_status, attached by bind.
// Observes ports only; every $past term is guarded by the previous reset level.
module led_err_status_chk #(
    parameter int unsigned NCH = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ch_on,
    input logic [NCH-1:0] ch_hot,
    input logic           die_hot,
    input logic           mode_clr,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] drive_en
);
    // R3: a channel that was off at the last edge cannot report healthy.
    assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status & ~$past(ch_on)) == '0));

    // R6: a channel that tripped at the last edge is not driven now.
    assert_chan_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((drive_en & $past(ch_hot)) == '0));

    // R9: a die trip removes all drive and all health on the next edge.
    assert_die_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(die_hot)) |-> (drive_en == '0 && status == '0));

    // R11: a trip together with a clear still leaves every bit at error.
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(die_hot) && $past(mode_clr)) |-> (status == '0));

    // R12: no drive without a drive request.
    assert_no_drive_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((drive_en & ~ch_on) == '0));
endmodule

bind led_err_status led_err_status_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_on   (ch_on),
    .ch_hot  (ch_hot),
    .die_hot (die_hot),
    .mode_clr(mode_clr),
    .status  (status),
    .drive_en(drive_en)
);

// File: tb/led_err_status_tb.sv
// Self-checking bench: directed corner cases followed by seeded random stimulus,
// compared against a reference model written from the requirements.
module led_err_status_tb;
    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] ch_on, open_flag, short_flag, ch_hot;
    logic           die_hot, mode_clr;
    logic [NCH-1:0] status, drive_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state.
    logic [NCH-1:0] m_live, m_therm, m_shut;
    logic           m_gshut;

    always #5 clk = ~clk;

    led_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .open_flag(open_flag),
        .short_flag(short_flag), .ch_hot(ch_hot), .die_hot(die_hot),
        .mode_clr(mode_clr), .status(status), .drive_en(drive_en)
    );

    function automatic logic [NCH-1:0] exp_status();
        return m_live & ~m_therm;
    endfunction

    function automatic logic [NCH-1:0] exp_drive();
        return ch_on & ~m_shut & ~{NCH{m_gshut}};
    endfunction

    // Advance the model by one rising edge using the inputs held at that edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_live = '0; m_therm = '0; m_shut = '0; m_gshut = 1'b0;
        end else begin
            m_live  = ch_on & ~open_flag & ~short_flag;
            m_therm = (m_therm & ~{NCH{mode_clr}}) | (ch_hot & ch_on) | {NCH{die_hot}};
            m_shut  = ch_hot;
            m_gshut = die_hot;
        end
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (status !== exp_status()) begin
            n_fail++;
            $display("FAIL %s status act=%h exp=%h", tag, status, exp_status());
        end
        n_chk++;
        if (drive_en !== exp_drive()) begin
            n_fail++;
            $display("FAIL %s drive_en act=%h exp=%h", tag, drive_en, exp_drive());
        end
    endtask

    // One clock: edge, model update, then sample at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic quiet();
        open_flag = '0; short_flag = '0; ch_hot = '0; die_hot = 0; mode_clr = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; ch_on = '0; quiet();
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");

        ch_on = '1;                        step("R2");
        ch_on = 16'h00FF; open_flag = 16'h8001; short_flag = 16'h4000; step("R3");
        quiet(); ch_on = '1; open_flag = 16'h0010; step("R4");
        open_flag = '0;                    step("R4");
        short_flag = 16'h8000;             step("R5");
        short_flag = '0; ch_hot = 16'h0004; step("R6");
        ch_hot = '0;                       step("R7");
        step("R8"); step("R8");
        mode_clr = 1;                      step("R10");
        mode_clr = 0;                      step("R10");
        die_hot = 1;                       step("R9");
        die_hot = 0;                       step("R9");
        step("R9");
        die_hot = 1; mode_clr = 1;         step("R11");
        die_hot = 0;                       step("R10");
        mode_clr = 0; ch_hot = 16'h0100; step("R6");
        ch_hot = 16'h0100; mode_clr = 1;   step("R11");
        ch_hot = '0; mode_clr = 0; ch_on = '0; open_flag = '1; step("R12");
        quiet();

        for (int k = 0; k < 3000; k++) begin
            ch_on      = $urandom | $urandom;
            open_flag  = $urandom & $urandom & $urandom & $urandom;
            short_flag = $urandom & $urandom & $urandom & $urandom;
            ch_hot     = $urandom & $urandom & $urandom & $urandom & $urandom;
            die_hot    = ($urandom % 40) == 0;
            mode_clr   = ($urandom % 12) == 0;
            step("random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule